// File: doc/BRIEF.md
# CCD Drive Timing Generator

This block derives every digital drive signal an interline-transfer CCD with field readout and a substrate electronic shutter needs from one master clock. The master clock runs at four times the pixel rate. A pixel-phase counter, a pixel counter within the line and a line counter within the field address the frame. Every output is a registered window compare against that position.

The outputs are as follows:
- Two complementary horizontal shift clocks. The last-stage clock of the horizontal register is tied to phase 1 outside the block.
- A narrow reset-gate pulse in each pixel period.
- A four-phase vertical transfer step sequence in the horizontal blanking gap of every line.
- One readout gate pulse per field. It goes to a different phase pair in each field, so adjacent rows mix in alternating pairings.
- Substrate drain pulses.
- A clamp pulse, a composite blanking flag and a field flag.

Frames interlace two fields. The first field after reset is one line longer than the second.

Exposure is set by the `shutter_lines` input, which is sampled once at the start of each field. A value S places drain pulses on the S lines that follow the readout line. This moves the last drain pulse S lines further from the previous readout and shortens charge storage to what remains before the next readout. A value of 0 disables the shutter. Values beyond the last usable line saturate. All outputs are logic level. Level shifting and the vertical driver sit outside the block.

Top module: `ccd_timing_gen`

## Requirements
- R1: A pixel period is 4 master clocks (phases 0..3). `h1` is high in phases 0 and 1, and `h2` is always the complement of `h1`.
- R2: `rg` is high in phase 0 of every pixel only, which is one quarter of the pixel period.
- R3: A line is H_LINE pixels (pixel 0..H_LINE-1). `clamp` is high on the H_FOB front optical-black pixels that follow the H_DUMMY dummy pixels.
- R4: `blank` is low only on pixels H_DUMMY+H_FOB .. +H_EFF-1 of field lines V_ACT_START .. +V_ACT_LINES-1.
- R5: Field 0 (`field_odd`=0) has FIELD_LINES+1 lines and field 1 has FIELD_LINES lines. `field_odd` toggles at each field boundary, and reset starts in field 0.
- R6: `vphase` (bit0=V1 .. bit3=V4) idles at 4'b0011. Starting at pixel VT_START it steps through 0110, 1100, 1001, 0011, each for VT_W pixels, on every line.
- R7: On field line RD_LINE, pixels SG_START .. +SG_W-1, the readout pulse is driven on `sg_a` in field 0 and on `sg_b` in field 1. Neither is driven anywhere else.
- R8: A sampled shutter value of 0 gives no `sub_pulse` in that field.
- R9: With sampled value S, `sub_pulse` is high on pixels SUB_START .. +SUB_W-1 of field lines RD_LINE+1 .. RD_LINE+S.
- R10: Shutter values above SMAX = FIELD_LINES-1-RD_LINE act as SMAX.
- R11: `shutter_lines` is sampled only when a new field begins. A change during a field has no effect on that field's drain pulses.
- R12: While `rst` is high, the outputs are: `h1`=1, `vphase`=4'b0011, `blank`=1, all others 0. After `rst` falls, each output reflects the counter position with one register of latency, and position 0 is the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, four per pixel |
| rst | input | 1 | Synchronous active-high reset |
| shutter_lines | input | SHUT_W | Drain line count, sampled at field start |
| h1 | output | 1 | Horizontal shift clock phase 1 |
| h2 | output | 1 | Horizontal shift clock phase 2 |
| rg | output | 1 | Reset-gate pulse |
| clamp | output | 1 | Optical-black clamp window |
| blank | output | 1 | Composite blanking, high outside the active window |
| vphase | output | 4 | Vertical transfer phases, bit0 = V1 |
| sg_a | output | 1 | Readout gate for field 0 |
| sg_b | output | 1 | Readout gate for field 1 |
| sub_pulse | output | 1 | Substrate drain pulse |
| field_odd | output | 1 | Field flag |

## Verification
The substrate drain window is placed so that it overlaps the vertical transfer steps in the horizontal blanking gap. A drained line therefore carries both functions in the same master-clock cycles. A second coincidence sits at the field boundary: the shutter value is sampled on the same edge that toggles the field flag and wraps the line counter. The bench runs a reduced geometry over many fields and changes the shutter value in the middle of each field. The values cover zero, small, saturating and maximum settings. Every output is compared on every cycle against an arithmetic model of the position, so an overlap error or a sample taken on the wrong edge shows as a mismatch on the affected pin.

// File: rtl/ccdtg_pkg.sv
package ccdtg_pkg;

    localparam int POS_W = 16;

    typedef struct packed {
        logic [1:0]       ph;     // phase within pixel
        logic [POS_W-1:0] h;      // pixel within line
        logic [POS_W-1:0] l;      // line within field
        logic             field;  // 0: long field, 1: short field
    } ccd_pos_t;

    localparam logic [3:0] V_IDLE = 4'b0011;

    function automatic logic in_win(input int x, input int lo, input int len);
        return (x >= lo) && (x < lo + len);
    endfunction

    function automatic logic [3:0] vpat(input int idx);
        case (idx)
            1:       return 4'b0110;
            2:       return 4'b1100;
            3:       return 4'b1001;
            default: return V_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/ccdtg_counters.sv
module ccdtg_counters
    import ccdtg_pkg::*;
#(
    parameter int H_LINE      = 910,
    parameter int FIELD_LINES = 262
) (
    input  logic     clk,
    input  logic     rst,
    output ccd_pos_t pos,
    output logic     field_end
);
    logic             pix_last, line_last;
    logic [POS_W-1:0] flines;

    always_comb begin
        pix_last  = (pos.ph == 2'd3);
        line_last = pix_last && (pos.h == POS_W'(H_LINE - 1));
        flines    = pos.field ? POS_W'(FIELD_LINES) : POS_W'(FIELD_LINES + 1);
        field_end = line_last && (pos.l == flines - POS_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else begin
            pos.ph <= pos.ph + 2'd1;
            if (pix_last)
                pos.h <= line_last ? '0 : pos.h + POS_W'(1);
            if (line_last) begin
                if (field_end) begin
                    pos.l     <= '0;
                    pos.field <= ~pos.field;
                end else begin
                    pos.l <= pos.l + POS_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/ccdtg_hgen.sv
module ccdtg_hgen
    import ccdtg_pkg::*;
#(
    parameter int H_DUMMY     = 22,
    parameter int H_FOB       = 3,
    parameter int H_EFF       = 768,
    parameter int V_ACT_START = 13,
    parameter int V_ACT_LINES = 247
) (
    input  logic     clk,
    input  logic     rst,
    input  ccd_pos_t pos,
    output logic     h1,
    output logic     h2,
    output logic     rg,
    output logic     clamp,
    output logic     blank
);
    localparam int ACT_H0 = H_DUMMY + H_FOB;

    int hi, li;
    always_comb begin
        hi = int'(pos.h);
        li = int'(pos.l);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h1    <= 1'b1;
            h2    <= 1'b0;
            rg    <= 1'b0;
            clamp <= 1'b0;
            blank <= 1'b1;
        end else begin
            h1    <= ~pos.ph[1];
            h2    <= pos.ph[1];
            rg    <= (pos.ph == 2'd0);
            clamp <= in_win(hi, H_DUMMY, H_FOB);
            blank <= !(in_win(hi, ACT_H0, H_EFF) && in_win(li, V_ACT_START, V_ACT_LINES));
        end
    end
endmodule

// File: rtl/ccdtg_vgen.sv
module ccdtg_vgen
    import ccdtg_pkg::*;
#(
    parameter int FIELD_LINES = 262,
    parameter int RD_LINE     = 3,
    parameter int VT_START    = 836,
    parameter int VT_W        = 4,
    parameter int SG_START    = 858,
    parameter int SG_W        = 36,
    parameter int SUB_START   = 840,
    parameter int SUB_W       = 23,
    parameter int SHUT_W      = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  ccd_pos_t          pos,
    input  logic              field_end,
    input  logic [SHUT_W-1:0] shutter_lines,
    output logic [3:0]        vphase,
    output logic              sg_a,
    output logic              sg_b,
    output logic              sub_pulse
);
    localparam int SMAX = FIELD_LINES - 1 - RD_LINE;

    logic [SHUT_W-1:0] lat;
    int hi, li, step;
    logic rd_hit, sub_hit;

    always_comb begin
        hi      = int'(pos.h);
        li      = int'(pos.l);
        step    = (hi - VT_START) / VT_W;
        rd_hit  = (li == RD_LINE) && in_win(hi, SG_START, SG_W);
        sub_hit = (li > RD_LINE) && (li - RD_LINE <= int'(lat)) &&
                  in_win(hi, SUB_START, SUB_W);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat       <= '0;
            vphase    <= V_IDLE;
            sg_a      <= 1'b0;
            sg_b      <= 1'b0;
            sub_pulse <= 1'b0;
        end else begin
            if (field_end)
                lat <= (int'(shutter_lines) > SMAX) ? SHUT_W'(SMAX) : shutter_lines;
            vphase    <= in_win(hi, VT_START, 4 * VT_W) ? vpat((step + 1) % 4) : V_IDLE;
            sg_a      <= rd_hit && !pos.field;
            sg_b      <= rd_hit && pos.field;
            sub_pulse <= sub_hit;
        end
    end
endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
    import ccdtg_pkg::*;
#(
    parameter int H_DUMMY     = 22,
    parameter int H_FOB       = 3,
    parameter int H_EFF       = 768,
    parameter int H_ROB       = 40,
    parameter int H_LINE      = 910,
    parameter int FIELD_LINES = 262,
    parameter int V_ACT_START = 13,
    parameter int V_ACT_LINES = 247,
    parameter int RD_LINE     = 3,
    parameter int VT_START    = 836,
    parameter int VT_W        = 4,
    parameter int SG_START    = 858,
    parameter int SG_W        = 36,
    parameter int SUB_START   = 840,
    parameter int SUB_W       = 23,
    parameter int SHUT_W      = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SHUT_W-1:0] shutter_lines,
    output logic              h1,
    output logic              h2,
    output logic              rg,
    output logic              clamp,
    output logic              blank,
    output logic [3:0]        vphase,
    output logic              sg_a,
    output logic              sg_b,
    output logic              sub_pulse,
    output logic              field_odd
);
    localparam int H_SHIFT = H_DUMMY + H_FOB + H_EFF + H_ROB;

    initial begin
        if (H_SHIFT > VT_START || VT_START + 4 * VT_W > SG_START ||
            SG_START + SG_W > H_LINE || SUB_START + SUB_W > H_LINE)
            $error("ccd_timing_gen: blanking windows do not fit the line");
    end

    ccd_pos_t pos;
    logic     field_end;

    ccdtg_counters #(.H_LINE(H_LINE), .FIELD_LINES(FIELD_LINES)) u_cnt (
        .clk(clk), .rst(rst), .pos(pos), .field_end(field_end)
    );

    ccdtg_hgen #(
        .H_DUMMY(H_DUMMY), .H_FOB(H_FOB), .H_EFF(H_EFF),
        .V_ACT_START(V_ACT_START), .V_ACT_LINES(V_ACT_LINES)
    ) u_hgen (
        .clk(clk), .rst(rst), .pos(pos),
        .h1(h1), .h2(h2), .rg(rg), .clamp(clamp), .blank(blank)
    );

    ccdtg_vgen #(
        .FIELD_LINES(FIELD_LINES), .RD_LINE(RD_LINE),
        .VT_START(VT_START), .VT_W(VT_W),
        .SG_START(SG_START), .SG_W(SG_W),
        .SUB_START(SUB_START), .SUB_W(SUB_W), .SHUT_W(SHUT_W)
    ) u_vgen (
        .clk(clk), .rst(rst), .pos(pos), .field_end(field_end),
        .shutter_lines(shutter_lines),
        .vphase(vphase), .sg_a(sg_a), .sg_b(sg_b), .sub_pulse(sub_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) field_odd <= 1'b0;
        else     field_odd <= pos.field;
    end
endmodule

// File: rtl/ccdtg_chk.sv
module ccdtg_chk (
    input logic       clk,
    input logic       rst,
    input logic       h1,
    input logic       h2,
    input logic       rg,
    input logic [3:0] vphase,
    input logic       sg_a,
    input logic       sg_b,
    input logic       sub_pulse,
    input logic       field_odd
);
    // R1
    h_compl_chk: assert property (@(posedge clk) disable iff (rst) h1 != h2);
    // R2
    rg_in_h1_chk: assert property (@(posedge clk) disable iff (rst) rg |-> h1);
    // R2
    rg_single_chk: assert property (@(posedge clk) disable iff (rst) rg |=> !rg);
    // R6
    vphase_pair_chk: assert property (@(posedge clk) disable iff (rst) $countones(vphase) == 2);
    // R6
    sg_v_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (sg_a || sg_b) |-> vphase == 4'b0011);
    // R7
    sg_excl_chk: assert property (@(posedge clk) disable iff (rst) !(sg_a && sg_b));
    // R7
    sg_field_chk: assert property (@(posedge clk) disable iff (rst)
        (sg_a |-> !field_odd) and (sg_b |-> field_odd));
    // R9
    sub_not_rd_chk: assert property (@(posedge clk) disable iff (rst)
        sub_pulse |-> !(sg_a || sg_b));
endmodule

bind ccd_timing_gen ccdtg_chk u_chk (
    .clk(clk), .rst(rst), .h1(h1), .h2(h2), .rg(rg), .vphase(vphase),
    .sg_a(sg_a), .sg_b(sg_b), .sub_pulse(sub_pulse), .field_odd(field_odd)
);

// File: tb/tb_ccd_timing_gen.sv
module tb_ccd_timing_gen;
    localparam int H_DUMMY = 2, H_FOB = 1, H_EFF = 8, H_ROB = 2, H_LINE = 40;
    localparam int FIELD_LINES = 9, V_ACT_START = 3, V_ACT_LINES = 4, RD_LINE = 1;
    localparam int VT_START = 14, VT_W = 2, SG_START = 24, SG_W = 8;
    localparam int SUB_START = 16, SUB_W = 6, SHUT_W = 4;
    localparam int SMAX = FIELD_LINES - 1 - RD_LINE;
    localparam int FR = 2 * FIELD_LINES + 1;
    localparam int NCYC = 10 * FR * H_LINE * 4;

    logic clk = 1'b0;
    logic rst;
    logic [SHUT_W-1:0] shutter_lines;
    logic h1, h2, rg, clamp, blank, sg_a, sg_b, sub_pulse, field_odd;
    logic [3:0] vphase;

    int nchk = 0, nfail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ccd_timing_gen #(
        .H_DUMMY(H_DUMMY), .H_FOB(H_FOB), .H_EFF(H_EFF), .H_ROB(H_ROB), .H_LINE(H_LINE),
        .FIELD_LINES(FIELD_LINES), .V_ACT_START(V_ACT_START), .V_ACT_LINES(V_ACT_LINES),
        .RD_LINE(RD_LINE), .VT_START(VT_START), .VT_W(VT_W), .SG_START(SG_START),
        .SG_W(SG_W), .SUB_START(SUB_START), .SUB_W(SUB_W), .SHUT_W(SHUT_W)
    ) dut (
        .clk(clk), .rst(rst), .shutter_lines(shutter_lines),
        .h1(h1), .h2(h2), .rg(rg), .clamp(clamp), .blank(blank), .vphase(vphase),
        .sg_a(sg_a), .sg_b(sg_b), .sub_pulse(sub_pulse), .field_odd(field_odd)
    );

    task automatic chk(input string req, input string nm, input int got, input int exp, input int cyc);
        nchk++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s %s cycle %0d: actual %0d expected %0d", req, nm, cyc, got, exp);
        end
    endtask

    // position of counter state k: phase, pixel, field line, field
    task automatic pos_of(input int k, output int ph, output int h, output int l, output int fld);
        int p, fl;
        ph = k % 4;
        p  = k / 4;
        h  = p % H_LINE;
        fl = (p / H_LINE) % FR;
        if (fl < FIELD_LINES + 1) begin fld = 0; l = fl; end
        else begin fld = 1; l = fl - (FIELD_LINES + 1); end
    endtask

    function automatic int win(input int x, input int lo, input int len);
        return (x >= lo && x < lo + len) ? 1 : 0;
    endfunction

    initial begin
        int lat, fi, ph, h, l, fld, e_v, s, subtag_sat;
        string stag;
        rst = 1'b1;
        shutter_lines = '0;
        lat = 0;
        fi = 0;
        subtag_sat = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12 reset values
        chk("R12", "h1", int'(h1), 1, 0);
        chk("R12", "h2", int'(h2), 0, 0);
        chk("R12", "rg", int'(rg), 0, 0);
        chk("R12", "blank", int'(blank), 1, 0);
        chk("R12", "vphase", int'(vphase), 3, 0);
        chk("R12", "sg", int'({sg_a, sg_b, sub_pulse, clamp, field_odd}), 0, 0);
        rst = 1'b0;
        for (int j = 1; j <= NCYC; j++) begin
            @(negedge clk);
            pos_of(j - 1, ph, h, l, fld);
            chk("R1", "h1", int'(h1), (ph < 2) ? 1 : 0, j);
            chk("R1", "h2", int'(h2), (ph < 2) ? 0 : 1, j);
            chk("R2", "rg", int'(rg), (ph == 0) ? 1 : 0, j);
            chk("R3", "clamp", int'(clamp), win(h, H_DUMMY, H_FOB), j);
            chk("R4", "blank", int'(blank),
                (win(h, H_DUMMY + H_FOB, H_EFF) && win(l, V_ACT_START, V_ACT_LINES)) ? 0 : 1, j);
            chk("R5", "field_odd", int'(field_odd), fld, j);
            e_v = 3;
            if (win(h, VT_START, 4 * VT_W) != 0)
                case (((h - VT_START) / VT_W + 1) % 4)
                    1: e_v = 6;
                    2: e_v = 12;
                    3: e_v = 9;
                    default: e_v = 3;
                endcase
            chk("R6", "vphase", int'(vphase), e_v, j);
            chk("R7", "sg_a", int'(sg_a), (l == RD_LINE && fld == 0) ? win(h, SG_START, SG_W) : 0, j);
            chk("R7", "sg_b", int'(sg_b), (l == RD_LINE && fld == 1) ? win(h, SG_START, SG_W) : 0, j);
            if (int'(shutter_lines) != lat && !(subtag_sat != 0)) stag = "R11";
            else if (lat == 0) stag = "R8";
            else if (subtag_sat != 0) stag = "R10";
            else stag = "R9";
            chk(stag, "sub_pulse", int'(sub_pulse),
                (l > RD_LINE && l - RD_LINE <= lat) ? win(h, SUB_START, SUB_W) : 0, j);
            // state j: sample shutter at field start
            pos_of(j, ph, h, l, fld);
            if (ph == 0 && h == 0 && l == 0) begin
                s = int'(shutter_lines);
                subtag_sat = (s > SMAX) ? 1 : 0;
                lat = (s > SMAX) ? SMAX : s;
            end
            // mid-field change of the shutter input (R11)
            if (ph == 0 && h == 0 && l == 5) begin
                fi++;
                shutter_lines = SHUT_W'((fi * 7) % 16);
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule